// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a clocked 64-bit-wide static memory with its own four-beat burst address counter and a registered read path. A processor or a cache controller begins an access by lowering one of two address strobes. The block then steps through the rest of the burst when the burst-advance input is asserted, or repeats the current beat when the input is held off. Holding the beat is how the bus master inserts wait states.

The two strobes follow different rules. The processor strobe always begins a read, and only while the chip is selected. When the chip is unselected, that strobe is ignored. The controller strobe begins a read or a write when the chip is selected, and deselects the memory when the chip is not selected. A static select input chooses the order of the beats. Interleaved order XORs the beat number into the two low address bits. Linear order adds the beat number modulo 4. Writes are masked per byte lane.

Read data appears on the output one clock after the access is registered. An active-low output enable can force the data pins to high impedance at any time, with no clock involved. The pins also float for writes, and from one clock after a deselect. The storage depth is a parameter: the full configuration uses a 15-bit address, and the default build uses a smaller array.

Top module: `psb_sram`

## Requirements
- R1: With `cs_n` low and `adsp_n` low, the edge loads `addr` and starts a read burst. A low `bw_n` bit has no effect and memory is not written.
- R2: With `cs_n` low, `adsp_n` high and `adsc_n` low, the edge loads `addr` and starts a burst. The access is a write when any bit of `bw_n` is low, and a read otherwise.
- R3: With `cs_n` high and `adsc_n` low, the edge deselects the block. `dq_drv` is low from the second edge onward, and continue cycles do nothing until a new start.
- R4: With `cs_n` high and only `adsp_n` low, no start and no deselect take place. During a burst the cycle acts as a continue or hold set by `adv_n`. When deselected, it does nothing.
- R5: With both strobes high during a burst, `adv_n` low moves to the next beat and `adv_n` high repeats the current beat. `bw_n` chooses write or read, for either value of `cs_n`.
- R6: `ilv_sel` high gives beat k the low bits start[1:0] XOR k. `ilv_sel` low gives (start[1:0] + k) mod 4. The upper address bits stay fixed, and the fifth beat returns to beat 0.
- R7: On a write, bit i of `bw_n` low stores `din[8i+7:8i]`, and lanes whose bit is high keep their old contents.
- R8: `dq_drv` is low, and `dq` is high impedance, while `oe_n` is high (with no clock edge needed), and after a write access.
- R9: A read registered on edge N shows its word on `dq`, with `dq_drv` high, after edge N+1 and not before. A write stores its data on the edge that registers it.
- R10: Synchronous active-low reset leaves the block deselected with `dq_drv` low. Continue cycles after reset do nothing, and memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | External word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_n | input | 1 | Chip select, active low |
| bw_n | input | DW/8 | Byte write enables, active low, bit i for lane i |
| ilv_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | DW | Write data |
| dq | output | DW | Read data; high impedance when not driven |
| dq_drv | output | 1 | High while `dq` is driven |

## Verification
On every cycle, the assertions check the strobe decode. The processor strobe never writes, a selected controller strobe with any byte enable low always writes, and the unselected processor strobe starts nothing. They also check that deselects and writes leave the pins floating two edges later, that every read drives the pins on time unless the output enable is off, and that a held beat keeps its address. Only the bench scenarios can show the data itself. Those scenarios cover the exact beat order in both modes, wraparound on the fifth beat, byte-lane merging, writes issued with the chip unselected, the asynchronous release by the output enable, and contents kept across reset.

// File: rtl/psb_pkg.sv
// Shared types and helpers for the pipelined burst SRAM.
// Assumes a four-beat burst, so the beat number is two bits wide.
package psb_pkg;

    // Kind of access decoded for the current clock edge
    typedef enum logic [2:0] {
        K_IDLE  = 3'd0,   // nothing happens
        K_START = 3'd1,   // load external address, beat 0
        K_DESEL = 3'd2,   // leave the burst, float outputs
        K_NEXT  = 3'd3,   // step to the following beat
        K_HOLD  = 3'd4    // repeat the current beat (wait state)
    } kind_e;

    // Low two address bits of beat k for a burst that started at s
    function automatic logic [1:0] beat_lo(input logic [1:0] s,
                                           input logic [1:0] k,
                                           input logic       ilv);
        return ilv ? (s ^ k) : (s + k);
    endfunction

endpackage

// File: rtl/psb_decode.sv
// Strobe decoder: turns chip select, both address strobes, the advance
// input and the byte enables into one access kind plus a write flag.
// Assumes: the processor strobe has priority and always means read;
// continue and hold cycles only take effect while a burst is active.
module psb_decode
    import psb_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic          cs_n,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic [NB-1:0] bw_n,
    input  logic          active,
    output kind_e         kind,
    output logic          wr
);

    logic any_byte;
    assign any_byte = ~&bw_n;

    // Priority decode of the cycle type
    always_comb begin
        kind = K_IDLE;
        wr   = 1'b0;
        if (!cs_n && !adsp_n) begin
            kind = K_START;
        end else if (!cs_n && !adsc_n) begin
            kind = K_START;
            wr   = any_byte;
        end else if (cs_n && !adsc_n) begin
            kind = K_DESEL;
        end else if (active) begin
            kind = adv_n ? K_HOLD : K_NEXT;
            wr   = any_byte;
        end
    end

endmodule

// File: rtl/psb_burst.sv
// Burst address generator: keeps the start address and beat count and
// produces the word address accessed on this edge.
// Assumes ilv_sel is static for the length of a burst.
module psb_burst
    import psb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  kind_e         kind,
    input  logic [AW-1:0] addr,
    input  logic          ilv_sel,
    output logic [AW-1:0] eff_addr,
    output logic          active
);

    localparam int HI_W = AW - 2;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_nx;

    assign cnt_nx = cnt_q + 2'd1;

    // Address presented to the array for this edge
    always_comb begin
        unique case (kind)
            K_START: eff_addr = addr;
            K_NEXT:  eff_addr = {base_q[AW-1:2], beat_lo(base_q[1:0], cnt_nx, ilv_sel)};
            K_HOLD:  eff_addr = {base_q[AW-1:2], beat_lo(base_q[1:0], cnt_q, ilv_sel)};
            default: eff_addr = base_q;
        endcase
    end

    // Burst state: start address, beat count and active flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            active <= 1'b0;
        end else begin
            unique case (kind)
                K_START: begin
                    base_q <= addr;
                    cnt_q  <= '0;
                    active <= 1'b1;
                end
                K_DESEL: active <= 1'b0;
                K_NEXT:  cnt_q  <= cnt_nx;
                default: ;
            endcase
        end
    end

    // R6: the upper address bits do not move inside a burst
    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active && (kind == K_NEXT || kind == K_HOLD)
        |-> eff_addr[AW-1:AW-HI_W] == $past(eff_addr[AW-1:AW-HI_W]));

    // R5: a hold cycle repeats the previous beat's address
    p_hold_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active && kind == K_HOLD |-> eff_addr == $past(eff_addr));

endmodule

// File: rtl/psb_array.sv
// Storage and read pipeline: byte-lane storage written on the access
// edge, read address registered on the access edge, data registered
// one edge later. Assumes DW is a multiple of 8.
module psb_array #(
    parameter int AW = 10,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW/8-1:0] be,
    input  logic          rd_en,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvld
);

    localparam int NB    = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          rq_q;
    logic [AW-1:0] ra_q;

    // First read stage: remember that a read was registered and where
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q <= 1'b0;
            ra_q <= '0;
        end else begin
            rq_q <= rd_en;
            if (rd_en) ra_q <= acc_addr;
        end
    end

    // Second read stage: output register valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) rvld <= 1'b0;
        else        rvld <= rq_q;
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] rd_q;

        // Lane write, masked by its byte enable
        always_ff @(posedge clk) begin
            if (we && be[i]) mem[acc_addr] <= wdata[8*i +: 8];
        end

        // Lane output register
        always_ff @(posedge clk) begin
            if (!rst_n)    rd_q <= '0;
            else if (rq_q) rd_q <= mem[ra_q];
        end

        assign rdata[8*i +: 8] = rd_q;
    end

    // R9: output register is loaded exactly one edge after a read access
    p_pipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 rvld);

endmodule

// File: rtl/psb_outdrv.sv
// Output stage: gates the registered read word onto the data pins with
// the asynchronous output enable. Assumes rvld is a registered flag.
module psb_outdrv #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] rdata,
    input  logic          rvld,
    input  logic          oe_n,
    output logic [DW-1:0] dq,
    output logic          dq_drv
);

    // Pin drive enable and three-state data
    assign dq_drv = rvld & ~oe_n;
    assign dq     = dq_drv ? rdata : {DW{1'bz}};

endmodule

// File: rtl/psb_sram.sv
// Pipelined burst SRAM top: decoder, burst address generator, storage
// with read pipeline, and three-state output stage.
// Assumes all inputs except oe_n are synchronous to clk.
module psb_sram
    import psb_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              cs_n,
    input  logic [DW/8-1:0]   bw_n,
    input  logic              ilv_sel,
    input  logic              oe_n,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dq,
    output logic              dq_drv
);

    localparam int NB = DW / 8;

    kind_e         kind;
    logic          wr;
    logic          active;
    logic [AW-1:0] eff_addr;
    logic          access;
    logic          mem_we;
    logic          rd_en;
    logic [DW-1:0] rdata;
    logic          rvld;

    psb_decode #(.NB(NB)) u_dec (
        .cs_n   (cs_n),
        .adsp_n (adsp_n),
        .adsc_n (adsc_n),
        .adv_n  (adv_n),
        .bw_n   (bw_n),
        .active (active),
        .kind   (kind),
        .wr     (wr)
    );

    psb_burst #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .addr     (addr),
        .ilv_sel  (ilv_sel),
        .eff_addr (eff_addr),
        .active   (active)
    );

    // Memory access strobes for this edge
    assign access = (kind == K_START) || (kind == K_NEXT) || (kind == K_HOLD);
    assign mem_we = access && wr;
    assign rd_en  = access && !wr;

    psb_array #(.AW(AW), .DW(DW)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mem_we),
        .be       (~bw_n),
        .rd_en    (rd_en),
        .acc_addr (eff_addr),
        .wdata    (din),
        .rdata    (rdata),
        .rvld     (rvld)
    );

    psb_outdrv #(.DW(DW)) u_out (
        .rdata  (rdata),
        .rvld   (rvld),
        .oe_n   (oe_n),
        .dq     (dq),
        .dq_drv (dq_drv)
    );

    // R1: the processor strobe never writes
    p_adsp_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n && !adsp_n |-> !mem_we);

    // R2: selected controller strobe with a byte enable writes
    p_adsc_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n && adsp_n && !adsc_n && !(&bw_n) |-> mem_we);

    // R3: deselect floats the pins after the following edge
    p_desel_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && !adsc_n |=> ##1 !dq_drv);

    // R4: unselected processor strobe starts nothing while deselected
    p_unsel_adsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && !adsp_n && adsc_n && !active |=> ##1 !dq_drv);

    // R8: a write access never drives the pins
    p_write_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ##1 !dq_drv);

    // R9: a read drives the pins after the next edge unless disabled
    p_read_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 (dq_drv || oe_n));

endmodule

// File: tb/tb_psb_sram.sv
`timescale 1ns/1ps
module tb_psb_sram;
    localparam int AW = 10;
    localparam int DW = 64;
    localparam int NB = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, cs_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic          ilv_sel = 1'b1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    wire  [DW-1:0] dq;
    logic          dq_drv;

    logic [DW-1:0] ref_mem [DEPTH];
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    psb_sram #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .cs_n(cs_n), .bw_n(bw_n), .ilv_sel(ilv_sel), .oe_n(oe_n),
        .din(din), .dq(dq), .dq_drv(dq_drv)
    );

    // Beat k address of a burst starting at b, per R6
    function automatic logic [AW-1:0] baddr(input logic [AW-1:0] b, input int k, input logic ilv);
        logic [1:0] kk;
        logic [1:0] lo;
        kk = k[1:0];
        lo = ilv ? (b[1:0] ^ kk) : 2'((b[1:0] + kk) % 4);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int seed);
        return {16'(seed) ^ 16'h3C5A, 6'd0, a, ~{6'd0, a}, 16'(seed * 7 + 1)};
    endfunction

    // One clock: inputs change 1 ns after the rising edge
    task automatic step(input logic cs, input logic sp, input logic sc, input logic av,
                        input logic [NB-1:0] bw, input logic [DW-1:0] d, input logic [AW-1:0] a);
        cs_n = cs; adsp_n = sp; adsc_n = sc; adv_n = av; bw_n = bw; din = d; addr = a;
        @(posedge clk); #1;
    endtask

    task automatic desel();
        step(1'b1, 1'b1, 1'b0, 1'b1, '1, '0, '0);
    endtask

    task automatic idle();
        step(1'b1, 1'b1, 1'b1, 1'b1, '1, '0, '0);
    endtask

    task automatic expect_q(input string req, input logic [DW-1:0] e);
        n_run++;
        if (dq_drv !== 1'b1 || dq !== e) begin
            n_fail++;
            $display("FAIL %s: dq_drv=%0b dq=%h, expected dq_drv=1 dq=%h", req, dq_drv, dq, e);
        end
    endtask

    task automatic expect_z(input string req);
        n_run++;
        if (dq_drv !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: dq_drv=%0b, expected 0", req, dq_drv);
        end
    endtask

    // R10: reset state and no bursting before a start
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) idle();
        expect_z("R10 reset state");
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b0, '1, '0, '0);
        idle();
        expect_z("R10 continue after reset");
    endtask

    // R2 start write, R5 continue writes with cs_n high
    task automatic t_write_burst(input logic [AW-1:0] base, input logic ilv, input int seed);
        ilv_sel = ilv;
        step(1'b0, 1'b1, 1'b0, 1'b1, '0, pat(base, seed), base);
        ref_mem[base] = pat(base, seed);
        for (int k = 1; k < 4; k++) begin
            logic [AW-1:0] a;
            a = baddr(base, k, ilv);
            step(1'b1, 1'b1, 1'b1, 1'b0, '0, pat(a, seed), '0);
            ref_mem[a] = pat(a, seed);
            if (k == 2) expect_z("R8 write cycle does not drive");
        end
        desel();
    endtask

    // R1 processor strobe reads despite byte enables, R6 order and wrap, R9 latency
    task automatic t_read_burst(input logic [AW-1:0] base, input logic ilv);
        ilv_sel = ilv;
        step(1'b0, 1'b0, 1'b1, 1'b1, '0, '1, base);
        expect_z("R9 no data before second edge");
        for (int k = 1; k <= 4; k++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0, '1, '0, '0);
            expect_q(k == 1 ? "R1 read start, memory unwritten" : "R6 beat order",
                     ref_mem[baddr(base, k - 1, ilv)]);
        end
        desel();
        expect_q("R6 fifth beat wraps to beat 0", ref_mem[base]);
        idle();
        expect_z("R3 float after deselect");
    endtask

    // R7 byte-lane masking, R2 read via controller strobe
    task automatic t_bytes();
        logic [AW-1:0] a;
        logic [DW-1:0] y;
        logic [NB-1:0] m;
        a = 10'h040;
        m = 8'hA5;
        y = 64'hF0E1_D2C3_B4A5_9687;
        step(1'b0, 1'b1, 1'b0, 1'b1, '0, 64'h1122_3344_5566_7788, a);
        ref_mem[a] = 64'h1122_3344_5566_7788;
        desel();
        step(1'b0, 1'b1, 1'b0, 1'b1, m, y, a);
        for (int i = 0; i < NB; i++)
            if (!m[i]) ref_mem[a][8*i +: 8] = y[8*i +: 8];
        desel();
        step(1'b0, 1'b1, 1'b0, 1'b1, '1, '0, a);
        desel();
        expect_q("R7 masked lanes (R2 read)", ref_mem[a]);
        idle();
    endtask

    // R5 hold repeats a beat, advance steps on
    task automatic t_suspend(input logic [AW-1:0] base);
        ilv_sel = 1'b1;
        step(1'b0, 1'b0, 1'b1, 1'b1, '1, '0, base);
        step(1'b1, 1'b1, 1'b1, 1'b1, '1, '0, '0);
        expect_q("R5 beat 0", ref_mem[base]);
        step(1'b0, 1'b1, 1'b1, 1'b0, '1, '0, '0);
        expect_q("R5 hold repeats beat 0", ref_mem[base]);
        step(1'b0, 1'b1, 1'b1, 1'b1, '1, '0, '0);
        expect_q("R5 advance to beat 1", ref_mem[baddr(base, 1, 1'b1)]);
        desel();
        expect_q("R5 hold repeats beat 1", ref_mem[baddr(base, 1, 1'b1)]);
        idle();
    endtask

    // R4 unselected processor strobe
    task automatic t_unsel(input logic [AW-1:0] base);
        ilv_sel = 1'b1;
        step(1'b0, 1'b0, 1'b1, 1'b1, '1, '0, base);
        step(1'b1, 1'b0, 1'b1, 1'b0, '1, '0, 10'h3FF);
        expect_q("R4 beat 0", ref_mem[base]);
        desel();
        expect_q("R4 strobe ignored, burst advanced", ref_mem[baddr(base, 1, 1'b1)]);
        idle();
        expect_z("R3 floated");
        step(1'b1, 1'b0, 1'b1, 1'b1, '1, '0, base);
        idle();
        expect_z("R4 no start while unselected");
    endtask

    // R8 asynchronous output enable
    task automatic t_oe(input logic [AW-1:0] a);
        step(1'b0, 1'b0, 1'b1, 1'b1, '1, '0, a);
        step(1'b1, 1'b1, 1'b1, 1'b1, '1, '0, '0);
        oe_n = 1'b1; #1;
        expect_z("R8 oe_n high floats pins");
        oe_n = 1'b0; #1;
        expect_q("R8 oe_n low drives without a clock", ref_mem[a]);
        desel();
        idle();
    endtask

    // R10 memory survives reset
    task automatic t_reset_keep(input logic [AW-1:0] a);
        rst_n = 1'b0;
        repeat (2) idle();
        rst_n = 1'b1;
        expect_z("R10 reset floats pins");
        step(1'b0, 1'b0, 1'b1, 1'b1, '1, '0, a);
        desel();
        expect_q("R10 contents kept", ref_mem[a]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_write_burst(10'h1A6, 1'b1, 3);
        t_read_burst(10'h1A6, 1'b1);
        t_write_burst(10'h2C7, 1'b0, 11);
        t_read_burst(10'h2C7, 1'b0);
        t_bytes();
        t_suspend(10'h1A6);
        t_unsel(10'h1A5);
        t_oe(10'h2C4);
        t_reset_keep(10'h1A7);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule